// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Sequencer

This block carries one display auxiliary-channel transaction from start to finish. A client presents a transaction type, a 20-bit target address, a byte count between 1 and 16 and up to 16 bytes of write data, then strobes `cmdStart`. The sequencer first waits for the channel to go quiet and takes ownership of it through a request/acknowledge handshake. It then confirms that a sink is attached, stages the write buffer and starts the transfer. The transfer itself is handed to a PHY stub that answers with a one-cycle completion strobe and an error-status word.

Each attempt opens with a one-cycle channel reset pulse. A failed attempt is retried after a guard delay, up to a parameterised attempt limit. When the transaction ends, on any path, the sequencer releases ownership and raises `done` for one cycle. The result code appears in the same cycle, and read data is returned for read types. All waits are counted in microsecond ticks taken from a parameterised clock divider.

Top module: `aux_txn_seq`

## Requirements
- R1: After `cmdStart`, no ownership request is raised while `chanBusy` or `reqPending` is high. If either is still high once IDLE_TMO_US microseconds have passed, the transaction ends with code 1 (busy).
- R2: `ownReq` is raised once the channel is idle and stays high until `ownAck` is seen. If no acknowledge arrives within ACK_TMO_US microseconds, the transaction ends with code 1 (busy). `phyStart` is never high while `ownReq` is low.
- R3: With ownership held, if `sinkPresent` is low the transaction ends with code 2 (no device). In that case no channel reset pulse and no `phyStart` are produced.
- R4: While `phyStart` is high, `phyCmd` carries the type in bits 15:12 and the byte count minus one in bits 3:0. Bits 11:4 are zero, and `phyAddr` holds the command address.
- R5: For a write type (type bit 0 clear), `phyWrData` holds the command data with every byte at index ≥ count forced to zero (byte i is bits 8i+7:8i). For a read type (type bit 0 set), a successful transaction returns `phyRdData` on `rdData` with the same byte masking.
- R6: Each attempt begins with `chanReset` high for exactly one cycle. On the first attempt `phyStart` rises one cycle after the pulse. On a retry at least GUARD_US microseconds pass between the pulse and `phyStart`.
- R7: `phyStart` stays high until `phyComplete`. If no completion arrives within DONE_TMO_US microseconds, the transaction ends with code 3 (timeout) without a retry. A completion in the same cycle as the expiry counts as a completion.
- R8: A completion with `phyErrStat` all zero ends the transaction with code 0 (ok). A nonzero status starts a new attempt. Once MAX_TRIES attempts have all failed, the transaction ends with code 4 (remote error).
- R9: `done` is a single-cycle pulse, `errCode` is valid in that cycle, and `ownReq` is low in that cycle on every exit path.
- R10: `cmdStart` is ignored while a transaction is in progress. The address and command driven to the PHY keep their values, and no extra `done` follows.
- R11: After reset, `done`, `ownReq`, `chanReset` and `phyStart` are low, and `errCode` and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Begin a transaction (taken only when idle) |
| cmdType | input | 4 | Transaction type; bit 0 set means read |
| cmdAddr | input | 20 | Target address |
| cmdLen | input | 5 | Byte count, 1 to 16 |
| cmdWrData | input | 128 | Write bytes, byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle end-of-transaction pulse |
| errCode | output | 3 | 0 ok, 1 busy, 2 no device, 3 timeout, 4 remote error |
| rdData | output | 128 | Read bytes from the last successful read |
| chanBusy | input | 1 | Channel busy flag from the PHY |
| reqPending | input | 1 | Another agent's request is pending |
| ownReq | output | 1 | Ownership request |
| ownAck | input | 1 | Ownership acknowledge |
| sinkPresent | input | 1 | Sink detected |
| chanReset | output | 1 | Channel reset pulse |
| phyCmd | output | 16 | Command word to the PHY |
| phyAddr | output | 20 | Address to the PHY |
| phyWrData | output | 128 | Staged write buffer |
| phyStart | output | 1 | Transfer request, held until completion |
| phyComplete | input | 1 | One-cycle completion strobe |
| phyErrStat | input | 8 | Error status sampled with completion |
| phyRdData | input | 128 | Read buffer from the PHY |

## Verification
The completion strobe and the expiry of the completion wait can land in the same cycle, and the sequencer must then treat the transfer as finished rather than timed out. The bench sweeps the PHY stub's response delay across that boundary one cycle at a time, from two cycles short of the limit to two cycles past it. For each delay it derives the expected code from the divider ratio and the timeout length: ok up to and including the coinciding cycle, timeout after it. The same arithmetic bounds the busy-path latencies and the guard gap seen between the reset pulse and the start request on retries.

// File: rtl/aux_txn_pkg.sv
package aux_txn_pkg;

  typedef enum logic [2:0] {
    ERR_OK      = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_NODEV   = 3'd2,
    ERR_TIMEOUT = 3'd3,
    ERR_REMOTE  = 3'd4
  } auxErr_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic    latchCmd;
    logic    loadWr;
    logic    captRd;
    logic    setErr;
    auxErr_e errVal;
  } auxStrobe_t;

endpackage

// File: rtl/aux_txn_timer.sv
module aux_txn_timer #(
  parameter int CLK_PER_US = 100,
  parameter int US_W       = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [US_W-1:0] usCnt
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else if (clr) begin
      divCnt <= '0;
      usCnt  <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick && (usCnt != '1)) usCnt <= usCnt + US_W'(1);
    end
  end
endmodule

// File: rtl/aux_txn_dp.sv
module aux_txn_dp
  import aux_txn_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 4,
  parameter int CMD_W  = 16,
  localparam int DATA_W = NBYTES * 8,
  localparam int LEN_W  = $clog2(NBYTES + 1),
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  auxStrobe_t        strb,
  input  logic [TYPE_W-1:0] cmdType,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [DATA_W-1:0] phyRdData,
  output logic              isRead,
  output logic [CMD_W-1:0]  phyCmd,
  output logic [ADDR_W-1:0] phyAddr,
  output logic [DATA_W-1:0] phyWrData,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        errCode
);
  localparam int PAD_W = CMD_W - TYPE_W - CNT_W;

  logic [TYPE_W-1:0] typeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  lenM1;
  logic [DATA_W-1:0] wrRawQ;
  logic [DATA_W-1:0] wrBufQ;
  logic [DATA_W-1:0] rdBufQ;
  logic [DATA_W-1:0] wrMasked;
  logic [DATA_W-1:0] rdMasked;
  logic [NBYTES-1:0] keepByte;
  auxErr_e           errQ;

  // byte lanes beyond the requested count are zeroed in both directions
  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
    assign keepByte[gi]          = (lenQ > LEN_W'(gi));
    assign wrMasked[gi*8 +: 8]   = keepByte[gi] ? wrRawQ[gi*8 +: 8]    : 8'h00;
    assign rdMasked[gi*8 +: 8]   = keepByte[gi] ? phyRdData[gi*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeQ  <= '0;
      addrQ  <= '0;
      lenQ   <= '0;
      wrRawQ <= '0;
      wrBufQ <= '0;
      rdBufQ <= '0;
      errQ   <= ERR_OK;
    end else begin
      if (strb.latchCmd) begin
        typeQ  <= cmdType;
        addrQ  <= cmdAddr;
        lenQ   <= cmdLen;
        wrRawQ <= cmdWrData;
      end
      if (strb.loadWr) wrBufQ <= wrMasked;
      if (strb.captRd) rdBufQ <= rdMasked;
      if (strb.setErr) errQ   <= strb.errVal;
    end
  end

  assign lenM1     = lenQ - LEN_W'(1);
  assign isRead    = typeQ[0];
  assign phyCmd    = {typeQ, {PAD_W{1'b0}}, lenM1[CNT_W-1:0]};
  assign phyAddr   = addrQ;
  assign phyWrData = wrBufQ;
  assign rdData    = rdBufQ;
  assign errCode   = errQ;
endmodule

// File: rtl/aux_txn_ctrl.sv
module aux_txn_ctrl
  import aux_txn_pkg::*;
#(
  parameter int IDLE_TMO_US = 1000,
  parameter int ACK_TMO_US  = 1000,
  parameter int DONE_TMO_US = 1000,
  parameter int GUARD_US    = 400,
  parameter int MAX_TRIES   = 32,
  parameter int ERR_W       = 8,
  parameter int US_W        = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdStart,
  input  logic             isRead,
  input  logic             chanBusy,
  input  logic             reqPending,
  input  logic             ownAck,
  input  logic             sinkPresent,
  input  logic             phyComplete,
  input  logic [ERR_W-1:0] phyErrStat,
  input  logic [US_W-1:0]  usCnt,
  output logic             tmrClr,
  output auxStrobe_t       strb,
  output logic             ownReq,
  output logic             chanReset,
  output logic             phyStart,
  output logic             done
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY  = TRY_W'(MAX_TRIES - 1);
  localparam logic [US_W-1:0]  IDLE_LIM  = US_W'(IDLE_TMO_US);
  localparam logic [US_W-1:0]  ACK_LIM   = US_W'(ACK_TMO_US);
  localparam logic [US_W-1:0]  DONE_LIM  = US_W'(DONE_TMO_US);
  localparam logic [US_W-1:0]  GUARD_LIM = US_W'(GUARD_US);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_IDLE, S_WAIT_ACK, S_SINK, S_RST_ON,
    S_RST_OFF, S_GUARD, S_WAIT_DONE, S_FINISH
  } state_e;

  state_e            state, nxt;
  logic [TRY_W-1:0]  tries;
  logic              attemptFail;

  always_comb begin
    nxt         = state;
    strb        = '0;
    attemptFail = 1'b0;
    case (state)
      S_IDLE: if (cmdStart) begin
        nxt           = S_WAIT_IDLE;
        strb.latchCmd = 1'b1;
      end
      S_WAIT_IDLE: begin
        if (!chanBusy && !reqPending) nxt = S_WAIT_ACK;
        else if (usCnt >= IDLE_LIM) begin
          nxt         = S_FINISH;
          strb.setErr = 1'b1;
          strb.errVal = ERR_BUSY;
        end
      end
      S_WAIT_ACK: begin
        if (ownAck) nxt = S_SINK;
        else if (usCnt >= ACK_LIM) begin
          nxt         = S_FINISH;
          strb.setErr = 1'b1;
          strb.errVal = ERR_BUSY;
        end
      end
      S_SINK: begin
        if (!sinkPresent) begin
          nxt         = S_FINISH;
          strb.setErr = 1'b1;
          strb.errVal = ERR_NODEV;
        end else begin
          nxt         = S_RST_ON;
          strb.loadWr = !isRead;
        end
      end
      S_RST_ON:  nxt = S_RST_OFF;
      S_RST_OFF: nxt = (tries != '0) ? S_GUARD : S_WAIT_DONE;
      S_GUARD:   if (usCnt >= GUARD_LIM) nxt = S_WAIT_DONE;
      S_WAIT_DONE: begin
        // a completion seen in the expiry cycle still counts as a completion
        if (phyComplete) begin
          if (phyErrStat == '0) begin
            nxt         = S_FINISH;
            strb.setErr = 1'b1;
            strb.errVal = ERR_OK;
            strb.captRd = isRead;
          end else if (tries == LAST_TRY) begin
            nxt         = S_FINISH;
            strb.setErr = 1'b1;
            strb.errVal = ERR_REMOTE;
          end else begin
            nxt         = S_RST_ON;
            attemptFail = 1'b1;
          end
        end else if (usCnt >= DONE_LIM) begin
          nxt         = S_FINISH;
          strb.setErr = 1'b1;
          strb.errVal = ERR_TIMEOUT;
        end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tries <= '0;
    end else begin
      state <= nxt;
      if (strb.latchCmd) tries <= '0;
      else if (attemptFail) tries <= tries + TRY_W'(1);
    end
  end

  assign tmrClr    = (nxt != state);
  assign ownReq    = (state inside {S_WAIT_ACK, S_SINK, S_RST_ON, S_RST_OFF, S_GUARD, S_WAIT_DONE});
  assign chanReset = (state == S_RST_ON);
  assign phyStart  = (state == S_WAIT_DONE);
  assign done      = (state == S_FINISH);
endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq
  import aux_txn_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int IDLE_TMO_US = 1000,
  parameter int ACK_TMO_US  = 1000,
  parameter int DONE_TMO_US = 1000,
  parameter int GUARD_US    = 400,
  parameter int MAX_TRIES   = 32,
  parameter int NBYTES      = 16,
  parameter int ADDR_W      = 20,
  parameter int ERR_W       = 8,
  localparam int DATA_W = NBYTES * 8,
  localparam int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdStart,
  input  logic [3:0]        cmdType,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic              done,
  output logic [2:0]        errCode,
  output logic [DATA_W-1:0] rdData,
  input  logic              chanBusy,
  input  logic              reqPending,
  output logic              ownReq,
  input  logic              ownAck,
  input  logic              sinkPresent,
  output logic              chanReset,
  output logic [15:0]       phyCmd,
  output logic [ADDR_W-1:0] phyAddr,
  output logic [DATA_W-1:0] phyWrData,
  output logic              phyStart,
  input  logic              phyComplete,
  input  logic [ERR_W-1:0]  phyErrStat,
  input  logic [DATA_W-1:0] phyRdData
);
  localparam int MAX_A = (IDLE_TMO_US > ACK_TMO_US) ? IDLE_TMO_US : ACK_TMO_US;
  localparam int MAX_B = (DONE_TMO_US > GUARD_US) ? DONE_TMO_US : GUARD_US;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int US_W  = $clog2(MAX_T + 1) + 1;

  auxStrobe_t      strb;
  logic            tmrClr;
  logic            isRead;
  logic [US_W-1:0] usCnt;

  aux_txn_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmrClr), .usCnt(usCnt)
  );

  aux_txn_ctrl #(
    .IDLE_TMO_US(IDLE_TMO_US), .ACK_TMO_US(ACK_TMO_US), .DONE_TMO_US(DONE_TMO_US),
    .GUARD_US(GUARD_US), .MAX_TRIES(MAX_TRIES), .ERR_W(ERR_W), .US_W(US_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .isRead(isRead),
    .chanBusy(chanBusy), .reqPending(reqPending), .ownAck(ownAck),
    .sinkPresent(sinkPresent), .phyComplete(phyComplete), .phyErrStat(phyErrStat),
    .usCnt(usCnt), .tmrClr(tmrClr), .strb(strb), .ownReq(ownReq),
    .chanReset(chanReset), .phyStart(phyStart), .done(done)
  );

  aux_txn_dp #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .TYPE_W(4), .CMD_W(16)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdType(cmdType), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdWrData(cmdWrData), .phyRdData(phyRdData), .isRead(isRead),
    .phyCmd(phyCmd), .phyAddr(phyAddr), .phyWrData(phyWrData), .rdData(rdData),
    .errCode(errCode)
  );
endmodule

// File: rtl/aux_txn_chk.sv
module aux_txn_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              ownReq,
  input logic              chanReset,
  input logic              phyStart,
  input logic              phyComplete,
  input logic [15:0]       phyCmd,
  input logic [ADDR_W-1:0] phyAddr
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                         // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ownReq);                                       // R9
  AST_START_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    phyStart |-> ownReq);                                    // R2
  AST_RESET_APART: assert property (@(posedge clk) disable iff (!rst_n)
    chanReset |=> !chanReset && !phyStart);                  // R6
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phyStart && !phyComplete) |=> (phyStart || done));      // R7
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phyStart && $past(phyStart)) |-> ($stable(phyCmd) && $stable(phyAddr))); // R10
endmodule

bind aux_txn_seq aux_txn_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .ownReq(ownReq), .chanReset(chanReset),
  .phyStart(phyStart), .phyComplete(phyComplete), .phyCmd(phyCmd), .phyAddr(phyAddr)
);

// File: tb/aux_txn_seq_test.sv
module aux_txn_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU   = 2;
  localparam int TMO   = 6;
  localparam int GUARD = 5;
  localparam int TRIES = 3;
  localparam int LIM   = TMO * CPU;

  logic clk = 0, rst_n = 0;
  logic cmdStart = 0;
  logic [3:0] cmdType = 0;
  logic [19:0] cmdAddr = 0;
  logic [4:0] cmdLen = 1;
  logic [127:0] cmdWrData = 0;
  logic done;
  logic [2:0] errCode;
  logic [127:0] rdData;
  logic chanBusy = 0, reqPending = 0, ownAck = 0, sinkPresent = 1;
  logic ownReq, chanReset, phyStart;
  logic [15:0] phyCmd;
  logic [19:0] phyAddr;
  logic [127:0] phyWrData;
  logic phyComplete = 0;
  logic [7:0] phyErrStat = 0;
  logic [127:0] phyRdData = 0;

  aux_txn_seq #(.CLK_PER_US(CPU), .IDLE_TMO_US(TMO), .ACK_TMO_US(TMO), .DONE_TMO_US(TMO),
    .GUARD_US(GUARD), .MAX_TRIES(TRIES)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // stub configuration (written by the test only)
  bit ackOn = 1;
  int failCount = 0, doneDelay = 2;
  // stub logs (written by the stub only)
  int attempts = 0, rstCount = 0, gapCnt = 0, waitCnt = 0;
  int gapLog [8];
  bit measuring = 0, ownPrev = 0;
  logic [15:0] cmdLog;
  logic [19:0] addrLog;
  logic [127:0] wrLog;
  // results from waitDone
  int lat;
  logic [2:0] gotErr;
  logic [127:0] gotRd;
  logic gotOwn, sawDone;

  always @(negedge clk) begin
    if (!rst_n) begin
      ownAck = 0; phyComplete = 0; attempts = 0; rstCount = 0; waitCnt = 0;
    end else begin
      ownAck = ackOn && ownReq;
      if (ownReq && !ownPrev) begin attempts = 0; rstCount = 0; measuring = 0; end
      ownPrev = ownReq;
      if (chanReset) begin rstCount++; gapCnt = 0; measuring = 1; end
      else if (measuring && !phyStart) gapCnt++;
      else if (measuring && phyStart) begin
        if (attempts < 8) gapLog[attempts] = gapCnt;
        measuring = 0; cmdLog = phyCmd; addrLog = phyAddr; wrLog = phyWrData;
      end
      phyComplete = 0;
      if (phyStart) begin
        if (waitCnt == doneDelay) begin
          phyComplete = 1;
          phyErrStat = (attempts < failCount) ? 8'h04 : 8'h00;
          attempts++; waitCnt = 0;
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !finished) begin
      finished = 1; bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=60000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: act=%h exp=%h", req, act, exp); end
  endtask

  function automatic logic [127:0] keepBytes(input logic [127:0] v, input int n);
    for (int i = 0; i < 16; i++) if (i >= n) v[i*8 +: 8] = 8'h00;
    return v;
  endfunction

  task automatic launch(input logic [3:0] t, input logic [19:0] a, input int l, input logic [127:0] w);
    cmdType = t; cmdAddr = a; cmdLen = 5'(l); cmdWrData = w; cmdStart = 1;
    @(negedge clk); cmdStart = 0; lat = 1;
  endtask

  task automatic waitDone;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    sawDone = done; gotErr = errCode; gotRd = rdData; gotOwn = ownReq;
    @(negedge clk);
    check(!done, "R9 done single", 128'(done), 128'd0);
  endtask

  task automatic runTxn(input logic [3:0] t, input logic [19:0] a, input int l, input logic [127:0] w);
    launch(t, a, l, w); waitDone();
  endtask

  initial begin
    logic [127:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!done && !ownReq && !chanReset && !phyStart && errCode == 0 && rdData == 0,
          "R11 reset state", {done, ownReq, chanReset, phyStart, errCode}, 0);

    // length sweep, writes and reads (R4, R5, R6, R8, R9)
    for (int l = 1; l <= 16; l++) begin
      for (int r = 0; r < 2; r++) begin
        logic [3:0] t;
        t = r ? 4'h9 : 4'h8;
        for (int i = 0; i < 16; i++) pat[i*8 +: 8] = 8'(8'h30 + i * 7 + l);
        phyRdData = ~pat;
        runTxn(t, 20'(20'h01000 + l), l, pat);
        check(sawDone && gotErr == 0, "R8 ok code", 128'(gotErr), 0);
        check(!gotOwn, "R9 ownership released", 128'(gotOwn), 0);
        check(cmdLog == {t, 8'h00, 4'(l - 1)}, "R4 command word", 128'(cmdLog), 128'({t, 8'h00, 4'(l - 1)}));
        check(addrLog == 20'(20'h01000 + l), "R4 address", 128'(addrLog), 128'(20'h01000 + l));
        if (r) check(gotRd == keepBytes(~pat, l), "R5 read masked", gotRd, keepBytes(~pat, l));
        else   check(wrLog == keepBytes(pat, l), "R5 write masked", wrLog, keepBytes(pat, l));
        check(rstCount == 1 && gapLog[0] <= 2, "R6 first attempt", 128'(gapLog[0]), 1);
      end
    end

    // retries that recover (R6, R8)
    for (int f = 1; f < TRIES; f++) begin
      failCount = f;
      runTxn(4'h8, 20'h0ABCD, 4, 128'h1122);
      check(gotErr == 0, "R8 recovered", 128'(gotErr), 0);
      check(attempts == f + 1 && rstCount == f + 1, "R6 reset per attempt", 128'(rstCount), 128'(f + 1));
      for (int k = 1; k <= f; k++)
        check(gapLog[k] >= GUARD * CPU, "R6 guard gap", 128'(gapLog[k]), 128'(GUARD * CPU));
    end
    failCount = TRIES;
    runTxn(4'h9, 20'h00010, 2, 0);
    check(gotErr == 4 && attempts == TRIES, "R8 remote error", 128'(gotErr), 4);
    check(!gotOwn, "R9 released on remote", 128'(gotOwn), 0);
    failCount = 0;

    // no sink (R3)
    sinkPresent = 0;
    runTxn(4'h8, 20'h00020, 1, 0);
    check(gotErr == 2, "R3 no device", 128'(gotErr), 2);
    check(attempts == 0 && rstCount == 0, "R3 no request", 128'(rstCount), 0);
    sinkPresent = 1;

    // ownership never acknowledged (R2)
    ackOn = 0;
    runTxn(4'h8, 20'h00030, 1, 0);
    check(gotErr == 1, "R2 ack timeout", 128'(gotErr), 1);
    check(lat >= LIM + 1 && lat <= LIM + 4, "R2 ack window", 128'(lat), 128'(LIM + 3));
    check(!gotOwn, "R2 released", 128'(gotOwn), 0);
    ackOn = 1;

    // busy never clears, pending never clears (R1)
    chanBusy = 1;
    runTxn(4'h8, 20'h00040, 1, 0);
    check(gotErr == 1 && lat >= LIM + 1 && lat <= LIM + 3, "R1 busy timeout", 128'(lat), 128'(LIM + 2));
    chanBusy = 0; reqPending = 1;
    runTxn(4'h8, 20'h00041, 1, 0);
    check(gotErr == 1, "R1 pending timeout", 128'(gotErr), 1);
    reqPending = 0;

    // busy clears after a few cycles: no request while busy (R1)
    chanBusy = 1;
    launch(4'h8, 20'h00050, 1, 0);
    begin
      bit early;
      early = 0;
      repeat (4) begin if (ownReq) early = 1; @(negedge clk); lat++; end
      check(!early, "R1 no request while busy", 128'(early), 0);
    end
    chanBusy = 0;
    waitDone();
    check(gotErr == 0, "R1 proceeds when idle", 128'(gotErr), 0);

    // completion vs timeout boundary (R7)
    for (int d = LIM - 2; d <= LIM + 2; d++) begin
      logic [2:0] exp;
      doneDelay = d;
      exp = (d <= LIM) ? 3'd0 : 3'd3;
      runTxn(4'h8, 20'h00060, 1, 0);
      check(gotErr == exp, "R7 completion boundary", 128'(gotErr), 128'(exp));
      if (d > LIM) check(attempts == 0, "R7 no retry on timeout", 128'(attempts), 0);
    end
    doneDelay = 8;

    // start ignored while running (R10)
    launch(4'h8, 20'h0AAAA, 3, 128'h55);
    repeat (4) @(negedge clk);
    lat += 4;
    cmdAddr = 20'h0BBBB; cmdType = 4'h9; cmdStart = 1;
    @(negedge clk); cmdStart = 0; lat++;
    waitDone();
    check(addrLog == 20'h0AAAA && cmdLog[15:12] == 4'h8, "R10 addr kept", 128'(addrLog), 128'(20'h0AAAA));
    begin
      bit extra;
      extra = 0;
      repeat (40) begin @(negedge clk); if (done) extra = 1; end
      check(!extra, "R10 no extra done", 128'(extra), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule